// File: doc/BRIEF.md
# Speculative Load Buffer with Visibility Tags

This block tracks loads that a core issues under speculation. It keeps their returned cache-line data away from the cache hierarchy. A circular load queue and a line-data buffer of equal depth share one head pointer and one tail pointer, so queue slot i always owns buffer slot i. Dispatch allocates a slot at the tail. Retirement frees the slot at the head. A squash moves the tail back to the oldest squashed slot.

When the address of a load resolves, the block classifies it:

- A load that is already safe is tagged not-needed and sent to the cache as a normal request.
- An unsafe load is sent as an invisible request. It is tagged with the kind of visibility transaction it will need later, either exposure or validation. The choice depends on the memory-ordering mode and on whether older loads have completed.

Line fills store a full line and a per-byte mask of the bytes the load consumed. A fill also marks the load as performed. An external invalidation whose line matches a validation-tagged entry raises a sticky early-squash flag for that entry. A read port lets the core inspect any slot.

Top module: `spec_load_buf`

## Requirements
- R1: After reset the queue is empty: `count` is 0, `alloc_ready` is 1 and `req_valid` is 0. While `count` equals DEPTH, `alloc_ready` is 0 and an allocation attempt changes nothing.
- R2: An accepted allocation takes the slot shown on `alloc_idx`, which then advances by one modulo DEPTH. The new slot reads as valid, not performed, with state N, and with the prefetch bit taken from `alloc_prefetch`. State codes are N=0, E=1 (needs exposure), V=2 (needs validation) and C=3 (visibility done).
- R3: A retire frees the oldest slot: `count` drops by one and that slot reads as not valid.
- R4: A squash at index k clears the valid bit of slot k and of every younger slot in one cycle. After the squash, `alloc_idx` equals k.
- R5: A resolve of a valid slot with `res_safe`=1 sets state N. On the next cycle it issues `req_valid` with `req_invisible`=0, carrying the slot index and line address.
- R6: With `mode_rc`=0, an unsafe resolve sets state V if any older valid slot is not yet performed, and sets E otherwise. In both cases the request has `req_invisible`=1.
- R7: With `mode_rc`=1, an unsafe resolve sets state V when `res_fence_older` is 1 and E when it is 0, whatever the older loads have done.
- R8: A fill to a valid slot stores `fill_data` and `fill_mask` and sets its performed bit.
- R9: `vis_done` moves a slot in state E or V to C. It leaves a slot in state N unchanged.
- R10: An invalidation sets bit i of `sq_flag` only if slot i is valid, in state V and holds the same line address. The flag stays set until the slot is freed. Slots in other states, and slots holding other lines, are not flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_rc | input | 1 | 0 = total store order, 1 = release consistency |
| alloc_valid | input | 1 | Allocate a slot for a dispatched load |
| alloc_prefetch | input | 1 | Load being allocated is a prefetch |
| alloc_ready | output | 1 | Allocation will be accepted this cycle |
| alloc_idx | output | IW | Slot index an allocation takes (tail) |
| retire_valid | input | 1 | Free the head slot |
| squash_valid | input | 1 | Squash from `squash_idx` to the tail |
| squash_idx | input | IW | Oldest squashed slot |
| res_valid | input | 1 | Address of a slot has resolved |
| res_idx | input | IW | Resolving slot |
| res_line | input | LW | Line address of the resolving load |
| res_safe | input | 1 | Load is safe under the attack model |
| res_fence_older | input | 1 | An older fence is in the window |
| req_valid | output | 1 | Cache request issued |
| req_idx | output | IW | Slot of the request |
| req_line | output | LW | Line address of the request |
| req_invisible | output | 1 | Request must not change cache state |
| fill_valid | input | 1 | Line data returned and delivered |
| fill_idx | input | IW | Slot receiving the fill |
| fill_data | input | DW | Line data |
| fill_mask | input | LINE_BYTES | Bytes consumed by the load |
| vis_done | input | 1 | Visibility transaction finished |
| vis_idx | input | IW | Slot whose transaction finished |
| inv_valid | input | 1 | External invalidation |
| inv_line | input | LW | Invalidated line address |
| sq_flag | output | DEPTH | Sticky early-squash flags per slot |
| count | output | IW+1 | Occupied slots |
| rd_idx | input | IW | Inspection index |
| rd_valid | output | 1 | Slot valid |
| rd_performed | output | 1 | Slot performed |
| rd_prefetch | output | 1 | Slot is a prefetch |
| rd_state | output | 2 | Slot visibility state |
| rd_data | output | DW | Slot line data |
| rd_mask | output | LINE_BYTES | Slot byte mask |

## Verification
The hardest case to reach is the split decision in ordering mode 0. It needs a resolve that sees a mix of performed and pending older loads, and then a resolve after the last older load has completed. The stimulus interleaves resolves and fills across four slots so that each outcome occurs. It then repeats an unsafe resolve in mode 1 with a pending older load present, so the two modes give different answers for the same situation. An early-squash flag is checked only after an invalidation that hits a validate-tagged line and after one that hits an expose-tagged line.

// File: rtl/spec_load_buf.sv
module spec_load_buf #(
  parameter int DEPTH      = 8,
  parameter int LINE_BYTES = 16,
  parameter int ADDR_W     = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1,
  localparam int LW = ADDR_W - $clog2(LINE_BYTES),
  localparam int DW = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_rc,
  input  logic                  alloc_valid,
  input  logic                  alloc_prefetch,
  output logic                  alloc_ready,
  output logic [IW-1:0]         alloc_idx,
  input  logic                  retire_valid,
  input  logic                  squash_valid,
  input  logic [IW-1:0]         squash_idx,
  input  logic                  res_valid,
  input  logic [IW-1:0]         res_idx,
  input  logic [LW-1:0]         res_line,
  input  logic                  res_safe,
  input  logic                  res_fence_older,
  output logic                  req_valid,
  output logic [IW-1:0]         req_idx,
  output logic [LW-1:0]         req_line,
  output logic                  req_invisible,
  input  logic                  fill_valid,
  input  logic [IW-1:0]         fill_idx,
  input  logic [DW-1:0]         fill_data,
  input  logic [LINE_BYTES-1:0] fill_mask,
  input  logic                  vis_done,
  input  logic [IW-1:0]         vis_idx,
  input  logic                  inv_valid,
  input  logic [LW-1:0]         inv_line,
  output logic [DEPTH-1:0]      sq_flag,
  output logic [PW-1:0]         count,
  input  logic [IW-1:0]         rd_idx,
  output logic                  rd_valid,
  output logic                  rd_performed,
  output logic                  rd_prefetch,
  output logic [1:0]            rd_state,
  output logic [DW-1:0]         rd_data,
  output logic [LINE_BYTES-1:0] rd_mask
);
  localparam logic [1:0] ST_N = 2'd0, ST_E = 2'd1, ST_V = 2'd2, ST_C = 2'd3;

  logic [PW-1:0]             head_p, tail_p;
  logic [DEPTH-1:0]          vld, perf, pref, kill;
  logic [DEPTH-1:0][1:0]     st;
  logic [LW-1:0]             tag  [DEPTH];
  logic [DW-1:0]             line [DEPTH];
  logic [LINE_BYTES-1:0]     bmask[DEPTH];

  logic [IW-1:0] head_idx, sq_off, res_off;
  logic          empty, full, alloc_fire, retire_fire, squash_fire, res_ok;
  logic          older_pending;
  logic [1:0]    res_state;
  logic [DEPTH-1:0][IW-1:0] off;

  assign head_idx    = head_p[IW-1:0];
  assign count       = tail_p - head_p;
  assign empty       = (count == '0);
  assign full        = (count == PW'(DEPTH));
  assign alloc_idx   = tail_p[IW-1:0];
  assign alloc_ready = !full && !squash_valid;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign retire_fire = retire_valid && !empty && !squash_valid;
  assign sq_off      = squash_idx - head_idx;
  assign squash_fire = squash_valid && (PW'(sq_off) < count);
  assign res_off     = res_idx - head_idx;
  assign res_ok      = res_valid && vld[res_idx];
  assign sq_flag     = kill;

  always_comb begin
    older_pending = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      off[i] = IW'(i) - head_idx;
      if (vld[i] && !perf[i] && off[i] < res_off) older_pending = 1'b1;
    end
  end

  always_comb begin
    if (res_safe)     res_state = ST_N;
    else if (mode_rc) res_state = res_fence_older ? ST_V : ST_E;
    else              res_state = older_pending   ? ST_V : ST_E;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_p <= '0;
      tail_p <= '0;
    end else begin
      if (retire_fire) head_p <= head_p + 1'b1;
      if (squash_fire)     tail_p <= head_p + PW'(sq_off);
      else if (alloc_fire) tail_p <= tail_p + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      perf <= '0;
      pref <= '0;
      kill <= '0;
      st   <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (res_ok && res_idx == IW'(i)) st[i] <= res_state;
        if (fill_valid && fill_idx == IW'(i) && vld[i]) perf[i] <= 1'b1;
        if (vis_done && vis_idx == IW'(i) && vld[i] &&
            (st[i] == ST_E || st[i] == ST_V)) st[i] <= ST_C;
        if (inv_valid && vld[i] && st[i] == ST_V && tag[i] == inv_line)
          kill[i] <= 1'b1;
        if ((retire_fire && head_idx == IW'(i)) ||
            (squash_fire && vld[i] && off[i] >= sq_off)) begin
          vld[i]  <= 1'b0;
          kill[i] <= 1'b0;
        end
        if (alloc_fire && alloc_idx == IW'(i)) begin
          vld[i]  <= 1'b1;
          perf[i] <= 1'b0;
          pref[i] <= alloc_prefetch;
          kill[i] <= 1'b0;
          st[i]   <= ST_N;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (res_ok && res_idx == IW'(i)) tag[i] <= res_line;
      if (fill_valid && fill_idx == IW'(i) && vld[i]) begin
        line[i]  <= fill_data;
        bmask[i] <= fill_mask;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid     <= 1'b0;
      req_idx       <= '0;
      req_line      <= '0;
      req_invisible <= 1'b0;
    end else begin
      req_valid <= res_ok;
      if (res_ok) begin
        req_idx       <= res_idx;
        req_line      <= res_line;
        req_invisible <= !res_safe;
      end
    end
  end

  assign rd_valid     = vld[rd_idx];
  assign rd_performed = perf[rd_idx];
  assign rd_prefetch  = pref[rd_idx];
  assign rd_state     = st[rd_idx];
  assign rd_data      = line[rd_idx];
  assign rd_mask      = bmask[rd_idx];
endmodule

module spec_load_buf_chk #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  mode_rc,
  input logic                  alloc_valid,
  input logic                  alloc_ready,
  input logic [IW-1:0]         alloc_idx,
  input logic                  retire_valid,
  input logic                  squash_valid,
  input logic [IW-1:0]         squash_idx,
  input logic [PW-1:0]         count,
  input logic                  res_valid,
  input logic [IW-1:0]         res_idx,
  input logic                  res_safe,
  input logic                  res_fence_older,
  input logic                  req_valid,
  input logic                  req_invisible,
  input logic [DEPTH-1:0]      vld,
  input logic [DEPTH-1:0][1:0] st,
  input logic [DEPTH-1:0]      kill
);
  // R1
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == PW'(DEPTH)) |-> !alloc_ready);

  // R2
  grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready && !retire_valid) |=> count == $past(count) + 1'b1);

  // R4
  rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_valid && vld[squash_idx]) |=> alloc_idx == $past(squash_idx));

  // R5
  safe_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && vld[res_idx] && res_safe) |=> (req_valid && !req_invisible));

  // R7
  rc_fence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rc && res_valid && vld[res_idx] && !res_safe && res_fence_older && !squash_valid)
    |=> st[$past(res_idx)] == 2'd2);

  // R10
  kill_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kill & ~vld) == '0);
endmodule

bind spec_load_buf spec_load_buf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_rc(mode_rc),
  .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
  .retire_valid(retire_valid), .squash_valid(squash_valid), .squash_idx(squash_idx),
  .count(count), .res_valid(res_valid), .res_idx(res_idx), .res_safe(res_safe),
  .res_fence_older(res_fence_older), .req_valid(req_valid), .req_invisible(req_invisible),
  .vld(vld), .st(st), .kill(kill)
);

// File: tb/spec_load_buf_bench.sv
`timescale 1ns/1ps
module spec_load_buf_bench;
  localparam int DEPTH = 8, LB = 16, AW = 32;
  localparam int IW = 3, LW = 28, DW = 128;

  logic clk = 0, rst_n = 0, mode_rc = 0;
  logic alloc_valid = 0, alloc_prefetch = 0, alloc_ready;
  logic [IW-1:0] alloc_idx;
  logic retire_valid = 0, squash_valid = 0;
  logic [IW-1:0] squash_idx = 0;
  logic res_valid = 0, res_safe = 0, res_fence_older = 0;
  logic [IW-1:0] res_idx = 0;
  logic [LW-1:0] res_line = 0;
  logic req_valid, req_invisible;
  logic [IW-1:0] req_idx;
  logic [LW-1:0] req_line;
  logic fill_valid = 0;
  logic [IW-1:0] fill_idx = 0;
  logic [DW-1:0] fill_data = 0;
  logic [LB-1:0] fill_mask = 0;
  logic vis_done = 0;
  logic [IW-1:0] vis_idx = 0;
  logic inv_valid = 0;
  logic [LW-1:0] inv_line = 0;
  logic [DEPTH-1:0] sq_flag;
  logic [IW:0] count;
  logic [IW-1:0] rd_idx = 0;
  logic rd_valid, rd_performed, rd_prefetch;
  logic [1:0] rd_state;
  logic [DW-1:0] rd_data;
  logic [LB-1:0] rd_mask;

  int n_cmp = 0, n_bad = 0;
  logic [IW+LW:0] expq[$];

  always #2.5 clk = ~clk;

  spec_load_buf #(.DEPTH(DEPTH), .LINE_BYTES(LB), .ADDR_W(AW)) u_spec_load_buf (.*);

  task automatic chk(input bit ok, input string r, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    alloc_valid = 0; retire_valid = 0; squash_valid = 0; res_valid = 0;
    fill_valid = 0; vis_done = 0; inv_valid = 0;
  endtask

  task automatic do_alloc(input bit pf, input int exp_idx);
    chk(alloc_ready, "R2 ready", alloc_ready, 1);
    chk(alloc_idx == IW'(exp_idx), "R2 alloc_idx", alloc_idx, exp_idx);
    alloc_valid = 1; alloc_prefetch = pf;
    tick();
  endtask

  task automatic peek_state(input int i, input logic [1:0] exp, input string r);
    rd_idx = IW'(i); #0.1;
    chk(rd_state == exp, r, rd_state, exp);
  endtask

  task automatic do_res(input int i, input bit safe, input bit fence, input logic [1:0] exp, input string r);
    res_valid = 1; res_idx = IW'(i); res_line = LW'(32'h100 + i);
    res_safe = safe; res_fence_older = fence;
    expq.push_back({IW'(i), LW'(32'h100 + i), !safe});
    tick();
    peek_state(i, exp, r);
  endtask

  task automatic do_fill(input int i);
    fill_valid = 1; fill_idx = IW'(i);
    fill_data = {4{32'hA5000000 + i}}; fill_mask = LB'(16'h00F0 << i);
    tick();
  endtask

  always @(negedge clk) begin
    if (rst_n && req_valid) begin
      if (expq.size() == 0) chk(0, "R5 unexpected request", req_idx, 0);
      else begin
        logic [IW+LW:0] e;
        e = expq.pop_front();
        chk({req_idx, req_line, req_invisible} == e, "R5/R6 request", {req_idx, req_line, req_invisible}, e);
      end
    end
  end

  initial begin
    #100000;
    chk(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #0.1;
    chk(count == 0, "R1 count", count, 0);
    chk(alloc_ready, "R1 ready", alloc_ready, 1);
    chk(!req_valid, "R1 req", req_valid, 0);

    do_alloc(0, 0); do_alloc(1, 1); do_alloc(0, 2); do_alloc(0, 3);
    chk(count == 4, "R2 count", count, 4);
    rd_idx = 1; #0.1;
    chk(rd_valid && rd_prefetch && !rd_performed && rd_state == 2'd0, "R2 fresh slot",
        {rd_valid, rd_prefetch, rd_performed, rd_state}, 5'b11000);

    do_res(0, 0, 0, 2'd1, "R6 no older -> E");
    do_res(1, 0, 0, 2'd2, "R6 older pending -> V");
    do_fill(0);
    rd_idx = 0; #0.1;
    chk(rd_performed, "R8 performed", rd_performed, 1);
    chk(rd_data == {4{32'hA5000000}}, "R8 data", rd_data, {4{32'hA5000000}});
    chk(rd_mask == 16'h00F0, "R8 mask", rd_mask, 16'h00F0);
    do_res(2, 0, 0, 2'd2, "R6 mixed older -> V");
    do_fill(1); do_fill(2);
    do_res(3, 0, 0, 2'd1, "R6 all older performed -> E");
    do_alloc(0, 4);
    do_res(4, 1, 0, 2'd0, "R5 safe -> N");

    inv_valid = 1; inv_line = LW'(32'h102); tick(); #0.1;
    chk(sq_flag == 8'h04, "R10 V slot flagged", sq_flag, 8'h04);
    inv_valid = 1; inv_line = LW'(32'h100); tick(); #0.1;
    chk(sq_flag == 8'h04, "R10 E slot not flagged", sq_flag, 8'h04);

    vis_done = 1; vis_idx = 2; tick();
    peek_state(2, 2'd3, "R9 V -> C");
    vis_done = 1; vis_idx = 4; tick();
    peek_state(4, 2'd0, "R9 N unchanged");

    mode_rc = 1;
    do_alloc(0, 5);
    do_res(5, 0, 1, 2'd2, "R7 fence -> V");
    do_alloc(0, 6);
    do_res(6, 0, 0, 2'd1, "R7 no fence -> E");

    squash_valid = 1; squash_idx = 5; tick(); #0.1;
    chk(count == 5, "R4 count", count, 5);
    chk(alloc_idx == 5, "R4 tail", alloc_idx, 5);
    rd_idx = 5; #0.1; chk(!rd_valid, "R4 slot5 cleared", rd_valid, 0);
    rd_idx = 6; #0.1; chk(!rd_valid, "R4 slot6 cleared", rd_valid, 0);
    rd_idx = 4; #0.1; chk(rd_valid, "R4 slot4 kept", rd_valid, 1);

    retire_valid = 1; tick(); #0.1;
    chk(count == 4, "R3 count", count, 4);
    rd_idx = 0; #0.1; chk(!rd_valid, "R3 head freed", rd_valid, 0);

    do_alloc(0, 5); do_alloc(0, 6); do_alloc(0, 7); do_alloc(0, 0);
    #0.1;
    chk(count == 8, "R1 full count", count, 8);
    chk(!alloc_ready, "R1 full refuses", alloc_ready, 0);
    alloc_valid = 1; tick(); #0.1;
    chk(count == 8, "R1 refused alloc", count, 8);
    chk(sq_flag == 8'h04, "R10 flag sticky", sq_flag, 8'h04);

    repeat (3) @(posedge clk);
    chk(expq.size() == 0, "R5 all requests seen", expq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule